// File: doc/BRIEF.md
# ADC Conversion Sequencer with Auto-Delay

This block is the digital controller in front of a multi-channel analog-to-digital converter. Software arms it with a start command. It then waits for a chosen edge on a trigger line, or starts at once in software-start mode, and walks through the channels enabled in a bitmask. It sends one single-cycle convert request per channel to the converter and accepts the result when the converter signals completion. Each result lands in a data register together with its channel number. An end-of-conversion flag follows every result, and an end-of-sequence flag follows the last channel.

Two options change the timing. In wait mode the sequencer holds back each conversion until software has read the previous result, so results are never overwritten. In auto-off mode the converter clock enable is low whenever nothing is pending. A trigger then raises it, and a fixed startup count must expire before the first request. When wait mode and auto-off mode are both set, the clock also drops while the sequencer waits for a read, and the startup delay runs again after the read. Continuous mode loops the sequence without a new trigger. Trigger edges that arrive during a running sequence are discarded.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the flags (end-of-conversion, end-of-sequence, overrun), the convert request and busy are all low. The clock enable is high while auto-off mode is clear.
- R2: With scan direction 0 the enabled channels are requested in ascending index order, one request pulse per channel, and only channels whose mask bit is 1 are requested.
- R3: With scan direction 1 the enabled channels are requested in descending index order.
- R4: The trigger-edge field selects how a sequence starts. Value 00 starts the sequence on the start command itself. Value 01 starts it on a rising trigger edge only, and a falling edge has no effect. Value 10 selects the falling edge and value 11 selects either edge.
- R5: Each result is placed in the data register with its channel number in the channel field, and the end-of-conversion flag is set. A data-register read clears the flag.
- R6: The end-of-sequence flag sets after the result of the last enabled channel. A write-one pulse clears it.
- R7: With wait mode clear, a result that arrives while the end-of-conversion flag is still set, and no read occurs in that cycle, sets the overrun flag. A write-one pulse on the overrun clear input clears it.
- R8: With wait mode set, no convert request is issued while the end-of-conversion flag is set, and overrun never sets.
- R9: With auto-off set, the clock enable is low whenever the sequencer is not busy. After a trigger the clock enable rises, and the first convert request comes exactly STARTUP_CYC cycles later.
- R10: With wait mode and auto-off both set, the clock enable is low while the sequencer waits for a read. After the read the startup delay of STARTUP_CYC cycles runs again before the next request.
- R11: With continuous mode set, the sequence restarts from its first channel without a new trigger. Clearing continuous mode lets the current sequence finish and stop.
- R12: Trigger edges that arrive while a sequence is running start no extra conversions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_i | input | 1 | Start command pulse (arms, or starts in software mode) |
| trig_i | input | 1 | Selected trigger line |
| edge_sel_i | input | 2 | Trigger edge: 00 software, 01 rising, 10 falling, 11 both |
| scan_dn_i | input | 1 | 0 ascending, 1 descending channel order |
| cont_i | input | 1 | Continuous mode |
| wait_i | input | 1 | Wait-for-read mode |
| auto_off_i | input | 1 | Auto clock-off mode |
| ch_mask_i | input | NCH | Enabled channel bitmask |
| conv_req_o | output | 1 | Convert request pulse |
| conv_ch_o | output | CHW | Channel for the current request |
| conv_done_i | input | 1 | Converter result valid |
| conv_data_i | input | DW | Converter result |
| clk_en_o | output | 1 | Converter clock enable |
| rdy_o | output | 1 | Startup delay expired |
| dr_read_i | input | 1 | Data-register read strobe |
| eoseq_clr_i | input | 1 | Write-one clear of end-of-sequence |
| ovr_clr_i | input | 1 | Write-one clear of overrun |
| data_o | output | DW | Data register |
| data_ch_o | output | CHW | Channel of the data register |
| eoc_o | output | 1 | End-of-conversion flag |
| eoseq_o | output | 1 | End-of-sequence flag |
| ovr_o | output | 1 | Overrun flag |
| busy_o | output | 1 | Sequence in progress |

## Verification
The assertions check, on every cycle, the rules that hold locally. A request targets an enabled channel and lasts one cycle. Reads and write-one strobes clear their flags. Overrun only rises out of an unread result outside wait mode. Wait mode never issues a request over an unread result. In auto-off mode the clock is low whenever the sequencer is idle, and it is high during any request. The channel order, the exact startup latency after the clock rises, the repeated startup after a held read, the looping of continuous mode, and the discarding of triggers during a run all span many cycles. Only the bench scenarios show these, by comparing the request stream and timing against the expected ones.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_WAKE,
    ST_ISSUE,
    ST_CONV,
    ST_HOLD
  } seq_st_e;

  localparam logic [1:0] EDGE_SW   = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_FALL = 2'b10;
  localparam logic [1:0] EDGE_BOTH = 2'b11;
endpackage

// File: rtl/adc_seq_rst_sync.sv
module adc_seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/adc_seq_trig.sv
module adc_seq_trig
  import adc_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       trig_i,
  input  logic [1:0] edge_sel_i,
  output logic       hit_o
);
  logic trig_q;
  logic rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_i;
  end

  assign rise = trig_i & ~trig_q;
  assign fall = ~trig_i & trig_q;

  always_comb begin
    case (edge_sel_i)
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_BOTH: hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_seq_pick.sv
module adc_seq_pick #(
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] mask_i,
  input  logic [CHW-1:0] cur_i,
  input  logic           dn_i,
  output logic           any_o,
  output logic [CHW-1:0] first_o,
  output logic [CHW-1:0] next_o,
  output logic           last_o
);
  logic [CHW-1:0] lo_idx, hi_idx, up_idx, dn_idx;
  logic           has_up, has_dn;

  always_comb begin
    lo_idx = '0;
    hi_idx = '0;
    up_idx = '0;
    dn_idx = '0;
    has_up = 1'b0;
    has_dn = 1'b0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (mask_i[i]) lo_idx = CHW'(i);
      if (mask_i[i] && (i > int'(cur_i))) begin
        up_idx = CHW'(i);
        has_up = 1'b1;
      end
    end
    for (int i = 0; i < NCH; i++) begin
      if (mask_i[i]) hi_idx = CHW'(i);
      if (mask_i[i] && (i < int'(cur_i))) begin
        dn_idx = CHW'(i);
        has_dn = 1'b1;
      end
    end
  end

  assign any_o   = |mask_i;
  assign first_o = dn_i ? hi_idx : lo_idx;
  assign next_o  = dn_i ? dn_idx : up_idx;
  assign last_o  = dn_i ? ~has_dn : ~has_up;
endmodule

// File: rtl/adc_seq_wake.sv
module adc_seq_wake #(
  parameter int STARTUP_CYC = 8,
  localparam int CW = $clog2(STARTUP_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic rdy_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = run_i ? cnt_q + CW'(1) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign rdy_o = run_i && (cnt_q == CW'(STARTUP_CYC - 1));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int NCH         = 8,
  parameter int DW          = 12,
  parameter int STARTUP_CYC = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start_i,
  input  logic           trig_i,
  input  logic [1:0]     edge_sel_i,
  input  logic           scan_dn_i,
  input  logic           cont_i,
  input  logic           wait_i,
  input  logic           auto_off_i,
  input  logic [NCH-1:0] ch_mask_i,
  output logic           conv_req_o,
  output logic [CHW-1:0] conv_ch_o,
  input  logic           conv_done_i,
  input  logic [DW-1:0]  conv_data_i,
  output logic           clk_en_o,
  output logic           rdy_o,
  input  logic           dr_read_i,
  input  logic           eoseq_clr_i,
  input  logic           ovr_clr_i,
  output logic [DW-1:0]  data_o,
  output logic [CHW-1:0] data_ch_o,
  output logic           eoc_o,
  output logic           eoseq_o,
  output logic           ovr_o,
  output logic           busy_o
);
  logic           rst_i_n;
  logic           hit;
  logic           any_ch, last_ch;
  logic [CHW-1:0] first_ch, next_ch;
  logic           wake_rdy;

  seq_st_e        st_q, st_d;
  logic [CHW-1:0] cur_q, cur_d;
  logic           eoc_q, eoc_d;
  logic           eoseq_q, eoseq_d;
  logic           ovr_q, ovr_d;
  logic [DW-1:0]  data_q;
  logic [CHW-1:0] dch_q;

  logic           done_ok;
  logic           launch;
  logic           eoc_pending;

  adc_seq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  adc_seq_trig u_trig (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .trig_i     (trig_i),
    .edge_sel_i (edge_sel_i),
    .hit_o      (hit)
  );

  adc_seq_pick #(.NCH(NCH)) u_pick (
    .mask_i  (ch_mask_i),
    .cur_i   (cur_q),
    .dn_i    (scan_dn_i),
    .any_o   (any_ch),
    .first_o (first_ch),
    .next_o  (next_ch),
    .last_o  (last_ch)
  );

  adc_seq_wake #(.STARTUP_CYC(STARTUP_CYC)) u_wake (
    .clk   (clk),
    .rst_n (rst_i_n),
    .run_i (st_q == ST_WAKE),
    .rdy_o (wake_rdy)
  );

  assign done_ok     = (st_q == ST_CONV) && conv_done_i;
  assign eoc_pending = eoc_q && !dr_read_i;

  // Sequence start decision
  always_comb begin
    launch = 1'b0;
    if (any_ch) begin
      if (st_q == ST_IDLE)
        launch = start_i && (edge_sel_i == EDGE_SW);
      else if (st_q == ST_ARMED)
        launch = (edge_sel_i == EDGE_SW) ? start_i : hit;
    end
  end

  // Next-state logic
  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    if (launch) begin
      cur_d = first_ch;
      if (wait_i && eoc_pending) st_d = ST_HOLD;
      else if (auto_off_i)       st_d = ST_WAKE;
      else                       st_d = ST_ISSUE;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start_i && (edge_sel_i != EDGE_SW)) st_d = ST_ARMED;
        end
        ST_ARMED: st_d = ST_ARMED;
        ST_WAKE: begin
          if (wake_rdy) st_d = ST_ISSUE;
        end
        ST_ISSUE: st_d = ST_CONV;
        ST_CONV: begin
          if (conv_done_i) begin
            if (!last_ch || cont_i) begin
              cur_d = last_ch ? first_ch : next_ch;
              st_d  = wait_i ? ST_HOLD : ST_ISSUE;
            end else begin
              st_d = (edge_sel_i == EDGE_SW) ? ST_IDLE : ST_ARMED;
            end
          end
        end
        ST_HOLD: begin
          if (dr_read_i) st_d = auto_off_i ? ST_WAKE : ST_ISSUE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  // Flag next values: a new event wins over a clear in the same cycle
  always_comb begin
    eoc_d   = done_ok ? 1'b1 : (dr_read_i ? 1'b0 : eoc_q);
    eoseq_d = (done_ok && last_ch) ? 1'b1 : (eoseq_clr_i ? 1'b0 : eoseq_q);
    ovr_d   = (done_ok && eoc_q && !dr_read_i && !wait_i) ? 1'b1
            : (ovr_clr_i ? 1'b0 : ovr_q);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q    <= ST_IDLE;
      cur_q   <= '0;
      eoc_q   <= 1'b0;
      eoseq_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cur_q   <= cur_d;
      eoc_q   <= eoc_d;
      eoseq_q <= eoseq_d;
      ovr_q   <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      data_q <= '0;
      dch_q  <= '0;
    end else if (done_ok) begin
      data_q <= conv_data_i;
      dch_q  <= cur_q;
    end
  end

  assign conv_req_o = (st_q == ST_ISSUE);
  assign conv_ch_o  = cur_q;
  assign clk_en_o   = !auto_off_i || (st_q == ST_WAKE) || (st_q == ST_ISSUE)
                      || (st_q == ST_CONV);
  assign rdy_o      = wake_rdy;
  assign busy_o     = (st_q != ST_IDLE) && (st_q != ST_ARMED);
  assign data_o     = data_q;
  assign data_ch_o  = dch_q;
  assign eoc_o      = eoc_q;
  assign eoseq_o    = eoseq_q;
  assign ovr_o      = ovr_q;
endmodule

// File: rtl/adc_seq_ctrl_chk.sv
module adc_seq_ctrl_chk #(
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wait_i,
  input logic           auto_off_i,
  input logic [NCH-1:0] ch_mask_i,
  input logic           conv_req_o,
  input logic [CHW-1:0] conv_ch_o,
  input logic           conv_done_i,
  input logic           clk_en_o,
  input logic           dr_read_i,
  input logic           eoseq_clr_i,
  input logic           eoc_o,
  input logic           eoseq_o,
  input logic           ovr_o,
  input logic           busy_o
);
  // R2
  req_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_o |-> ch_mask_i[conv_ch_o]);

  // R2
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_o |=> !conv_req_o);

  // R5
  eoc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dr_read_i && !conv_done_i) |=> !eoc_o);

  // R6
  eoseq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoseq_clr_i && !conv_done_i) |=> !eoseq_o);

  // R7
  ovr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_o) |-> $past(!wait_i && eoc_o));

  // R8
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_i && eoc_o) |-> !conv_req_o);

  // R9
  idle_clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_off_i && !busy_o) |-> !clk_en_o);

  // R9
  req_clk_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req_o |-> clk_en_o);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wait_i      (wait_i),
  .auto_off_i  (auto_off_i),
  .ch_mask_i   (ch_mask_i),
  .conv_req_o  (conv_req_o),
  .conv_ch_o   (conv_ch_o),
  .conv_done_i (conv_done_i),
  .clk_en_o    (clk_en_o),
  .dr_read_i   (dr_read_i),
  .eoseq_clr_i (eoseq_clr_i),
  .eoc_o       (eoc_o),
  .eoseq_o     (eoseq_o),
  .ovr_o       (ovr_o),
  .busy_o      (busy_o)
);

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  localparam int NCH = 8;
  localparam int DW  = 12;
  localparam int SU  = 8;
  localparam int LAT = 3;
  localparam int CHW = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start_i = 1'b0, trig_i = 1'b0;
  logic [1:0]     edge_sel_i = 2'b00;
  logic           scan_dn_i = 1'b0, cont_i = 1'b0, wait_i = 1'b0, auto_off_i = 1'b0;
  logic [NCH-1:0] ch_mask_i = '0;
  logic           conv_req_o;
  logic [CHW-1:0] conv_ch_o;
  logic           conv_done_i = 1'b0;
  logic [DW-1:0]  conv_data_i = '0;
  logic           clk_en_o, rdy_o;
  logic           dr_read_i;
  logic           rd_auto = 1'b0, rd_man = 1'b0;
  logic           eoseq_clr_i = 1'b0, ovr_clr_i = 1'b0;
  logic [DW-1:0]  data_o;
  logic [CHW-1:0] data_ch_o;
  logic           eoc_o, eoseq_o, ovr_o, busy_o;

  assign dr_read_i = rd_auto | rd_man;

  always #2 clk = ~clk;

  adc_seq_ctrl #(.NCH(NCH), .DW(DW), .STARTUP_CYC(SU)) u_dut (.*);

  int n_chk = 0, n_fail = 0;
  int exp_q[$];
  int req_seen = 0;
  bit auto_rd = 1'b0;
  int lat_cnt = 0;
  bit chk_due = 1'b0;
  logic [CHW-1:0] cur_ch = '0;
  logic [DW-1:0]  cur_data = '0;
  logic [7:0]     nconv = '0;

  function automatic void check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  task automatic push_exp(input int ch);
    exp_q.push_back(ch);
  endtask

  // Converter model and scoreboard monitor
  always @(negedge clk) begin
    rd_auto = 1'b0;
    if (chk_due) begin
      chk_due = 1'b0;
      check(data_o == cur_data, "R5 data register", int'(data_o), int'(cur_data));
      check(data_ch_o == cur_ch, "R5 data channel", int'(data_ch_o), int'(cur_ch));
      check(eoc_o == 1'b1, "R5 eoc set", int'(eoc_o), 1);
      if (auto_rd) rd_auto = 1'b1;
    end
    conv_done_i = 1'b0;
    if (lat_cnt != 0) begin
      lat_cnt--;
      if (lat_cnt == 0) begin
        conv_done_i = 1'b1;
        conv_data_i = cur_data;
        chk_due = 1'b1;
      end
    end
    if (conv_req_o) begin
      lat_cnt  = LAT;
      cur_ch   = conv_ch_o;
      cur_data = DW'(int'(cur_ch) * 256 + int'(nconv));
      nconv++;
      req_seen++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2/R3/R11/R12 unexpected request", int'(conv_ch_o), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        check(int'(conv_ch_o) == e, "R2/R3 channel order", int'(conv_ch_o), e);
      end
    end
  end

  task automatic wait_idle();
    do @(negedge clk); while (!busy_o);
    while (busy_o) @(negedge clk);
  endtask

  task automatic rise_trig();
    trig_i = 1'b0;
    @(negedge clk);
    trig_i = 1'b1;
    @(negedge clk);
  endtask

  task automatic pulse_read();
    rd_man = 1'b1;
    @(negedge clk);
    rd_man = 1'b0;
  endtask

  task automatic measure_startup(input string tag);
    int n;
    while (!clk_en_o) @(negedge clk);
    n = 0;
    while (!conv_req_o && n < 100) begin
      @(negedge clk);
      n++;
    end
    check(n == SU, tag, n, SU);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int base;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1
    check(!eoc_o && !eoseq_o && !ovr_o, "R1 flags clear", int'({eoc_o, eoseq_o, ovr_o}), 0);
    check(!conv_req_o && !busy_o, "R1 idle", int'({conv_req_o, busy_o}), 0);
    check(clk_en_o, "R1 clock on", int'(clk_en_o), 1);

    // R2 R4 R7: software start, ascending, no reads
    ch_mask_i = 8'hA6;
    push_exp(1); push_exp(2); push_exp(5); push_exp(7);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o, "R4 software start", int'(busy_o), 1);
    wait_idle();
    check(exp_q.size() == 0, "R2 all channels done", exp_q.size(), 0);
    check(eoseq_o, "R6 eoseq set", int'(eoseq_o), 1);
    check(ovr_o, "R7 overrun set", int'(ovr_o), 1);
    eoseq_clr_i = 1'b1; @(negedge clk); eoseq_clr_i = 1'b0;
    check(!eoseq_o, "R6 eoseq cleared", int'(eoseq_o), 0);
    pulse_read();
    check(!eoc_o, "R5 eoc cleared by read", int'(eoc_o), 1'b0);
    ovr_clr_i = 1'b1; @(negedge clk); ovr_clr_i = 1'b0;
    check(!ovr_o, "R7 overrun cleared", int'(ovr_o), 0);

    // R3 R4 R12: rising edge, descending, auto reads
    auto_rd = 1'b1;
    edge_sel_i = 2'b01;
    scan_dn_i = 1'b1;
    ch_mask_i = 8'h89;
    trig_i = 1'b1;
    @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    base = req_seen;
    trig_i = 1'b0;
    repeat (20) @(negedge clk);
    check(!busy_o && req_seen == base, "R4 falling edge ignored", req_seen - base, 0);
    push_exp(7); push_exp(3); push_exp(0);
    trig_i = 1'b1;
    do @(negedge clk); while (!busy_o);
    trig_i = 1'b0; @(negedge clk); trig_i = 1'b1; @(negedge clk);
    while (busy_o) @(negedge clk);
    repeat (30) @(negedge clk);
    check(req_seen - base == 3, "R12 mid-run trigger ignored", req_seen - base, 3);
    check(!busy_o, "R12 idle after run", int'(busy_o), 0);
    check(!ovr_o, "R7 no overrun with reads", int'(ovr_o), 0);
    eoseq_clr_i = 1'b1; @(negedge clk); eoseq_clr_i = 1'b0;

    // R8: wait mode holds until read
    auto_rd = 1'b0;
    wait_i = 1'b1;
    scan_dn_i = 1'b0;
    ch_mask_i = 8'h05;
    push_exp(0); push_exp(2);
    base = req_seen;
    rise_trig();
    repeat (30) @(negedge clk);
    check(req_seen - base == 1, "R8 held before read", req_seen - base, 1);
    check(eoc_o && busy_o, "R8 eoc pending while held", int'({eoc_o, busy_o}), 3);
    pulse_read();
    while (busy_o) @(negedge clk);
    check(req_seen - base == 2, "R8 resumed after read", req_seen - base, 2);
    check(!ovr_o, "R8 no overrun", int'(ovr_o), 0);
    pulse_read();
    eoseq_clr_i = 1'b1; @(negedge clk); eoseq_clr_i = 1'b0;

    // R9: auto-off startup delay
    wait_i = 1'b0;
    auto_off_i = 1'b1;
    auto_rd = 1'b1;
    ch_mask_i = 8'h10;
    @(negedge clk);
    check(!clk_en_o, "R9 clock off when idle", int'(clk_en_o), 0);
    push_exp(4);
    rise_trig();
    measure_startup("R9 startup delay");
    while (busy_o) @(negedge clk);
    @(negedge clk);
    check(!clk_en_o, "R9 clock off after run", int'(clk_en_o), 0);

    // R10: wait + auto-off
    auto_rd = 1'b0;
    wait_i = 1'b1;
    ch_mask_i = 8'h03;
    push_exp(0); push_exp(1);
    rise_trig();
    measure_startup("R10 first startup");
    repeat (20) @(negedge clk);
    check(!clk_en_o && busy_o, "R10 clock off while held", int'({clk_en_o, busy_o}), 1);
    pulse_read();
    measure_startup("R10 startup after read");
    while (busy_o) @(negedge clk);
    pulse_read();
    eoseq_clr_i = 1'b1; @(negedge clk); eoseq_clr_i = 1'b0;

    // R11: continuous mode
    wait_i = 1'b0;
    auto_off_i = 1'b0;
    auto_rd = 1'b1;
    cont_i = 1'b1;
    ch_mask_i = 8'h42;
    push_exp(1); push_exp(6); push_exp(1); push_exp(6);
    base = req_seen;
    rise_trig();
    while (req_seen - base < 4) @(negedge clk);
    cont_i = 1'b0;
    while (busy_o) @(negedge clk);
    repeat (30) @(negedge clk);
    check(req_seen - base == 4, "R11 looped then stopped", req_seen - base, 4);
    check(exp_q.size() == 0, "R11 queue drained", exp_q.size(), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule